// File: doc/BRIEF.md
# Three-channel down-counting timer bank with watchdog reset

The block holds several 32-bit down-counters that software drives through a single-cycle register port. A channel that is enabled loses one count per selected tick. When a channel reaches zero and counts once more, it expires. In periodic mode an expiring channel reloads from its reload register. In one-shot mode it halts at zero, and the hardware clears its enable bit. Each expiry latches a cause bit. A mask register decides which cause bits drive the interrupt line. A channel loaded with all ones and set to reload all ones runs as a free timebase, and elapsed ticks are all-ones minus the value read.

The last channel doubles as a watchdog. When it expires while the reset-out enable bit is set, it raises a reset request. That request stays high until the block's own reset is applied. Each channel can count either on every system clock or only on cycles where the slower reference tick-enable input is high.

The register port has no back-pressure. A write with `bus_wr` high is accepted at the next rising edge. Reads are combinational from `bus_addr` and return live values. There is no valid/ready handshake because every access completes in one cycle.

Top module: `timer_bank`

## Requirements
- R1: Register map: control at 0x00, reset-out enable at 0x04 (bit 0), cause at 0x08, mask at 0x0C. Channel i's counter sits at 0x10+8*i and its reload register at 0x14+8*i. All registers read back what was written, or the live count.
- R2: Control holds a 4-bit field per channel i: bit 4i enables, bit 4i+1 selects auto-reload, bit 4i+2 selects the reference tick. An enabled channel on the system clock decrements once per rising edge.
- R3: In one-shot mode, a channel that is at zero and receives a tick expires, stays at zero, and has its enable bit cleared by hardware.
- R4: In periodic mode, a channel that is at zero and receives a tick expires and loads its reload value.
- R5: With the reference select set, a channel counts only on edges where `ref_tick` is high.
- R6: A channel whose enable bit is clear holds its count. A bus write to a counter takes effect at the next edge and overrides that edge's decrement.
- R7: Every expiry sets its cause bit (bit i for channel i), and the bit stays set. Writing the cause register clears exactly the bits written as 0. If an expiry and a clear hit the same bit in the same cycle, the expiry wins.
- R8: `irq` is high when any cause bit is set whose mask bit is 0. A mask bit of 1 blocks its cause.
- R9: An expiry of the last channel while the reset-out enable is 1 raises `wd_rst_req`. It then stays high until `rst_n` is low. With the enable at 0, no request is raised.
- R10: After reset, every register reads zero except the mask, which reads all ones in its low NUM_CH bits. `irq` and `wd_rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Single-cycle enable of the slow reference rate |
| bus_wr | input | 1 | Write strobe, accepted at the next edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Masked interrupt request |
| wd_rst_req | output | 1 | Held watchdog reset request |

## Verification
A corrupted count shows up in the very next read of that counter, because reads return the live value. It also shifts the expiry, and with it the cause bit and `irq`, by the size of the error. A wrong mode bit or a missed hardware clear of the enable bit shows as a reload where a halt was expected, or as repeated expiries. The bench catches this within the few cycles after the first expiry. A lost watchdog latch appears as `wd_rst_req` falling without a reset, and the bench checks for that cycles after the control has been cleared.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int unsigned OFF_CTRL     = 0;
  localparam int unsigned OFF_RSTEN    = 4;
  localparam int unsigned OFF_CAUSE    = 8;
  localparam int unsigned OFF_MASK     = 12;
  localparam int unsigned OFF_CNT_BASE = 16;
  localparam int unsigned OFF_RL_BASE  = 20;
  localparam int unsigned CH_STRIDE    = 8;

  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_AUTO = 1;
  localparam int unsigned BIT_REF  = 2;

  function automatic int unsigned cnt_addr(input int unsigned ch);
    return OFF_CNT_BASE + CH_STRIDE * ch;
  endfunction

  function automatic int unsigned rl_addr(input int unsigned ch);
    return OFF_RL_BASE + CH_STRIDE * ch;
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             auto_rl,
  input  logic             use_ref,
  input  logic             ref_tick,
  input  logic             cnt_we,
  input  logic             rl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, rl_q;
  logic             tick;

  assign tick   = use_ref ? ref_tick : 1'b1;
  assign expire = run && tick && (cnt_q == '0) && !cnt_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else begin
      if (rl_we) rl_q <= wdata;
      if (cnt_we) begin
        cnt_q <= wdata;
      end else if (run && tick) begin
        if (cnt_q == '0) begin
          if (auto_rl) cnt_q <= rl_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign count      = cnt_q;
  assign reload_val = rl_q;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire,
  input  logic              cause_we,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] cause,
  output logic [NUM_CH-1:0] mask,
  output logic              irq
);
  logic [NUM_CH-1:0] cause_q, mask_q, cause_kept;

  always_comb begin
    cause_kept = cause_we ? (cause_q & wdata) : cause_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= cause_kept | expire;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign cause = cause_q;
  assign mask  = mask_q;
  assign irq   = |(cause_q & ~mask_q);
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rst_en,
  output logic rst_req
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else if (expire && rst_en) req_q <= 1'b1;
  end

  assign rst_req = req_q;
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wd_rst_req
);
  localparam int unsigned CTRL_W = FIELD_W * NUM_CH;
  localparam int unsigned WD_CH  = NUM_CH - 1;

  logic [CTRL_W-1:0]              ctrl_q;
  logic                           rsten_q;
  logic [NUM_CH-1:0]              expire, cnt_we, rl_we, cnt_rd, rl_rd;
  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_all, rl_all;
  logic [NUM_CH-1:0]              cause_q, mask_q;
  logic                           ctrl_we, rsten_we, cause_we, mask_we;

  assign ctrl_we  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign rsten_we = bus_wr && (bus_addr == ADDR_W'(OFF_RSTEN));
  assign cause_we = bus_wr && (bus_addr == ADDR_W'(OFF_CAUSE));
  assign mask_we  = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign cnt_rd[g] = (bus_addr == ADDR_W'(cnt_addr(g)));
    assign rl_rd[g]  = (bus_addr == ADDR_W'(rl_addr(g)));
    assign cnt_we[g] = bus_wr && cnt_rd[g];
    assign rl_we[g]  = bus_wr && rl_rd[g];

    tmr_channel #(.CNT_W(DATA_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ctrl_q[FIELD_W*g + BIT_EN]),
      .auto_rl    (ctrl_q[FIELD_W*g + BIT_AUTO]),
      .use_ref    (ctrl_q[FIELD_W*g + BIT_REF]),
      .ref_tick   (ref_tick),
      .cnt_we     (cnt_we[g]),
      .rl_we      (rl_we[g]),
      .wdata      (bus_wdata),
      .count      (cnt_all[g]),
      .reload_val (rl_all[g]),
      .expire     (expire[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rsten_q <= 1'b0;
    end else begin
      if (rsten_we) rsten_q <= bus_wdata[0];
      if (ctrl_we) begin
        ctrl_q <= bus_wdata[CTRL_W-1:0];
      end else begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (expire[i] && !ctrl_q[FIELD_W*i + BIT_AUTO])
            ctrl_q[FIELD_W*i + BIT_EN] <= 1'b0;
        end
      end
    end
  end

  tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .cause_we (cause_we),
    .mask_we  (mask_we),
    .wdata    (bus_wdata[NUM_CH-1:0]),
    .cause    (cause_q),
    .mask     (mask_q),
    .irq      (irq)
  );

  tmr_wdog u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire[WD_CH]),
    .rst_en  (rsten_q),
    .rst_req (wd_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL))  bus_rdata[CTRL_W-1:0] = ctrl_q;
    if (bus_addr == ADDR_W'(OFF_RSTEN)) bus_rdata[0]          = rsten_q;
    if (bus_addr == ADDR_W'(OFF_CAUSE)) bus_rdata[NUM_CH-1:0] = cause_q;
    if (bus_addr == ADDR_W'(OFF_MASK))  bus_rdata[NUM_CH-1:0] = mask_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cnt_rd[i]) bus_rdata = cnt_all[i];
      if (rl_rd[i])  bus_rdata = rl_all[i];
    end
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [FIELD_W*NUM_CH-1:0]     ctrl,
  input logic                          rsten,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt,
  input logic [NUM_CH-1:0]             cause,
  input logic                          irq,
  input logic                          wd_rst_req
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R6: stopped channel with no counter write keeps its value
    a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[FIELD_W*g + BIT_EN] && !(bus_wr && bus_addr == ADDR_W'(cnt_addr(g))))
      |=> $stable(cnt[g]));
    // R3: one-shot expiry halts at zero with enable cleared
    a_r3_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[FIELD_W*g + BIT_EN] && !ctrl[FIELD_W*g + BIT_AUTO] &&
       !ctrl[FIELD_W*g + BIT_REF] && cnt[g] == '0 && !bus_wr)
      |=> (!ctrl[FIELD_W*g + BIT_EN] && cnt[g] == '0));
  end

  // R7: without a cause write no set bit is lost
  a_r7_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(OFF_CAUSE))
    |=> ((cause & $past(cause)) == $past(cause)));

  // R8: no pending cause means no interrupt
  a_r8_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == '0) |-> !irq);

  // R9: reset request holds once raised
  a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> wd_rst_req);

  // R9: request only rises while reset-out is enabled
  a_r9_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_req) |-> $past(rsten));
endmodule

bind timer_bank timer_bank_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .ctrl       (ctrl_q),
  .rsten      (rsten_q),
  .cnt        (cnt_all),
  .cause      (cause_q),
  .irq        (irq),
  .wd_rst_req (wd_rst_req)
);

// File: tb/tb_timer_bank.sv
module tb_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wd_rst_req;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  timer_bank dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wd_rst_req(wd_rst_req)
  );

  typedef struct packed {
    int          ch;
    logic [31:0] load;
    logic        auto_rl;
    logic [31:0] rl;
    int          wait_n;
    logic [31:0] exp_cnt;
    logic [2:0]  exp_cause;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{0, 32'd5, 1'b0, 32'd0,  3, 32'd2,  3'b000},
    '{0, 32'd5, 1'b0, 32'd0,  6, 32'd0,  3'b001},
    '{0, 32'd5, 1'b0, 32'd0,  9, 32'd0,  3'b001},
    '{1, 32'd3, 1'b1, 32'd10, 4, 32'd10, 3'b010},
    '{1, 32'd3, 1'b1, 32'd10, 6, 32'd8,  3'b010},
    '{1, 32'd2, 1'b1, 32'd4,  8, 32'd4,  3'b010},
    '{0, 32'd0, 1'b1, 32'd0,  3, 32'd0,  3'b001},
    '{2, 32'd1, 1'b0, 32'd0,  2, 32'd0,  3'b100},
    '{2, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 10, 32'hFFFF_FFF5, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(6'h00, rv); chk("R10 ctrl", rv, 32'h0);
    rd(6'h0C, rv); chk("R10 mask", rv, 32'h7);
    rd(6'h08, rv); chk("R10 cause", rv, 32'h0);
    rd(6'h10, rv); chk("R10 cnt0", rv, 32'h0);
    rd(6'h24, rv); chk("R10 rl2", rv, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);
    chk("R10 wd_rst_req", {31'b0, wd_rst_req}, 32'h0);

    // R1 reload readback at channel 1
    wr(6'h1C, 32'h1234_5678);
    rd(6'h1C, rv); chk("R1 rl1", rv, 32'h1234_5678);

    // Table: R2 counting, R3 one-shot, R4 periodic, R7 cause
    foreach (VECS[i]) begin
      wr(6'h00, 32'h0);
      wr(6'h08, 32'h0);
      wr(6'(20 + 8*VECS[i].ch), VECS[i].rl);
      wr(6'(16 + 8*VECS[i].ch), VECS[i].load);
      wr(6'h00, (32'h1 | (32'(VECS[i].auto_rl) << 1)) << (4*VECS[i].ch));
      idle(VECS[i].wait_n);
      rd(6'(16 + 8*VECS[i].ch), rv); chk("R2/R3/R4 count", rv, VECS[i].exp_cnt);
      rd(6'h08, rv); chk("R7 cause", rv, {29'b0, VECS[i].exp_cause});
    end

    // R9: earlier channel-2 expiry with reset-out disabled raised nothing
    chk("R9 suppressed", {31'b0, wd_rst_req}, 32'h0);

    // R3: one-shot clears its enable bit
    wr(6'h00, 32'h0);
    wr(6'h10, 32'd2);
    wr(6'h00, 32'h1);
    idle(4);
    rd(6'h00, rv); chk("R3 enable cleared", rv, 32'h0);

    // R5: reference tick select
    wr(6'h10, 32'd5);
    wr(6'h00, 32'h5);
    idle(5);
    rd(6'h10, rv); chk("R5 no tick", rv, 32'd5);
    ref_tick = 1'b1;
    idle(2);
    ref_tick = 1'b0;
    rd(6'h10, rv); chk("R5 two ticks", rv, 32'd3);

    // R6: running write overrides, stopped holds
    wr(6'h00, 32'h0);
    wr(6'h10, 32'd100);
    wr(6'h00, 32'h1);
    idle(3);
    rd(6'h10, rv); chk("R2 running", rv, 32'd97);
    wr(6'h10, 32'd50);
    rd(6'h10, rv); chk("R6 write wins", rv, 32'd50);
    wr(6'h00, 32'h0);
    idle(4);
    rd(6'h10, rv); chk("R6 stopped hold", rv, 32'd49);

    // R7 / R8: cause clearing and masking
    wr(6'h08, 32'h0);
    wr(6'h10, 32'd0);
    wr(6'h18, 32'd0);
    wr(6'h00, 32'h11);
    idle(2);
    rd(6'h08, rv); chk("R7 both set", rv, 32'h3);
    chk("R8 masked", {31'b0, irq}, 32'h0);
    wr(6'h0C, 32'h6);
    chk("R8 unmasked", {31'b0, irq}, 32'h1);
    wr(6'h08, 32'hFFFF_FFFD);
    rd(6'h08, rv); chk("R7 clear bit1 only", rv, 32'h1);
    chk("R8 still pending", {31'b0, irq}, 32'h1);
    wr(6'h08, 32'hFFFF_FFFE);
    chk("R8 cleared", {31'b0, irq}, 32'h0);

    // R9: watchdog reset request
    wr(6'h04, 32'h1);
    wr(6'h20, 32'd3);
    wr(6'h00, 32'h100);
    idle(3);
    chk("R9 before expiry", {31'b0, wd_rst_req}, 32'h0);
    idle(1);
    chk("R9 raised", {31'b0, wd_rst_req}, 32'h1);
    wr(6'h00, 32'h0);
    wr(6'h04, 32'h0);
    idle(2);
    chk("R9 held", {31'b0, wd_rst_req}, 32'h1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 cleared by reset", {31'b0, wd_rst_req}, 32'h0);
    rd(6'h0C, rv); chk("R10 mask after reset", rv, 32'h7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule